// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching translation descriptors from memory. A requester supplies the virtual address and the base of the first-level table. The walker then issues one word read, or two when the first descriptor points to a second-level table. It returns the physical address, the page granule, the memory attribute and access-permission bits, the domain number, and a fault indication that tells which level faulted.

The first-level table covers the 4 GB space in 1 MB slots. A slot can fault, map a 1 MB section, map a 16 MB supersection, or point to a 1 KB second-level table. A second-level entry covers 4 KB and can fault, map a 64 KB large page, or map a 4 KB small page. Memory is reached through a plain word-read port. The walker holds its request until the response strobe arrives, so any read latency is allowed. The walker does not check permissions and keeps no translations.

Top module: `ptw_walker`

## Requirements
- R1: A walk starts on a cycle with `req_valid` high and `busy` low. `busy` is high from the next cycle until the cycle that `done` pulses. `req_valid` is ignored while `busy` is high, so the result belongs to the first accepted address.
- R2: The first read address is `{req_base[31:14], vaddr[31:20], 2'b00}`. Bits [13:0] of the base are ignored.
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk after one read. It gives `res_fault`=1 and `res_fault_level`=0, and `res_paddr`, `res_size` and every attribute and domain output are zero.
- R4: First-level bits [1:0] = 1x with bit 18 clear is a section, `res_size`=2. `res_paddr` = `{d[31:20], vaddr[19:0]}`. The fields are b=d[2], c=d[3], xn=d[4], domain=d[8:5], ap={d[15],d[11:10]}, tex=d[14:12], s=d[16], ng=d[17].
- R5: First-level bits [1:0] = 1x with bit 18 set is a supersection, `res_size`=3. `res_paddr` = `{d[31:24], vaddr[23:0]}`. The attributes are taken as in R4, but the domain is 0.
- R6: First-level bits [1:0] = 01 points to a second-level table. The second read address is `{d1[31:10], vaddr[19:12], 2'b00}`.
- R7: A second-level descriptor with bits [1:0] = 00 gives `res_fault`=1 and `res_fault_level`=1. All other result outputs are zero.
- R8: Second-level bits [1:0] = 01 is a large page, `res_size`=1. `res_paddr` = `{d2[31:16], vaddr[15:0]}`. The fields are b=d2[2], c=d2[3], ap={d2[9],d2[5:4]}, s=d2[10], ng=d2[11], tex=d2[14:12], xn=d2[15]. The domain is first-level d1[8:5].
- R9: Second-level bits [1:0] = 1x is a small page, `res_size`=0. `res_paddr` = `{d2[31:12], vaddr[11:0]}`. The fields are xn=d2[0], b=d2[2], c=d2[3], ap={d2[9],d2[5:4]}, tex=d2[8:6], s=d2[10], ng=d2[11]. The domain is d1[8:5].
- R10: `mem_req_valid` stays high with a stable `mem_req_addr` until the cycle that `mem_resp_valid` is sampled high. A walk makes exactly one read, or two when a table is followed.
- R11: `done` is a one-cycle pulse. All `res_*` outputs change only on the cycle `done` rises and hold until the next walk completes. After reset, `busy`, `done` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base (bits [31:14] used) |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Word read request |
| mem_req_addr | output | 32 | Word read address |
| mem_resp_valid | input | 1 | Read data valid, completes the request |
| mem_resp_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| res_paddr | output | 32 | Physical address |
| res_size | output | 2 | 0 small, 1 large, 2 section, 3 supersection |
| res_tex | output | 3 | Type extension bits |
| res_c | output | 1 | Cacheable bit |
| res_b | output | 1 | Bufferable bit |
| res_s | output | 1 | Shareable bit |
| res_ap | output | 3 | Access permission bits |
| res_xn | output | 1 | Execute-never bit |
| res_ng | output | 1 | Non-global bit |
| res_domain | output | 4 | Domain number |
| res_fault | output | 1 | Translation fault |
| res_fault_level | output | 1 | 0 first level, 1 second level |

## Verification
The walker is driven with random bases, addresses and descriptors of all six outcomes: first-level fault, section, supersection, second-level fault, large page and small page. Each walk compares the result with a model, so a swapped field or wrong splice point shows up for one granule only. Random response delays separate a correctly held request from one that re-issues or moves its address. Stray requests during a walk, and bases with their low bits set, separate correct ignoring from corruption of the read address. Directed walks use the 0x000F_0000 table with virtual 0x0010_0000, which must read 0x000F_0004.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int unsigned VA_W        = 32;
    localparam int unsigned PA_W        = 32;
    localparam int unsigned DESC_W      = 32;
    localparam int unsigned L1_IDX_LSB  = 20;
    localparam int unsigned L2_IDX_LSB  = 12;
    localparam int unsigned L1_BASE_LSB = 14;
    localparam int unsigned L2_BASE_LSB = 10;
    localparam int unsigned L1_IDX_W    = VA_W - L1_IDX_LSB;
    localparam int unsigned L2_IDX_W    = L1_IDX_LSB - L2_IDX_LSB;
    localparam int unsigned L2_BASE_W   = DESC_W - L2_BASE_LSB;
    localparam int unsigned DOM_W       = 4;
    localparam int unsigned SUPER_BIT   = 18;

    typedef enum logic [1:0] {
        PG_SMALL   = 2'd0,
        PG_LARGE   = 2'd1,
        PG_SECTION = 2'd2,
        PG_SUPER   = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_RD1  = 2'd1,
        WS_RD2  = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic [PA_W-1:0]  paddr;
        pg_size_e         size;
        logic [2:0]       tex;
        logic             c;
        logic             b;
        logic             s;
        logic [2:0]       ap;
        logic             xn;
        logic             ng;
        logic [DOM_W-1:0] domain;
        logic             fault;
        logic             flevel;
    } walk_res_t;

    function automatic walk_res_t res_zero();
        walk_res_t r;
        r = '0;
        return r;
    endfunction
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0]    desc,
    input  logic [VA_W-1:0]      vaddr,
    output logic                 is_table,
    output logic [L2_BASE_W-1:0] l2_base,
    output logic [DOM_W-1:0]     l1_domain,
    output walk_res_t            res
);
    logic unused_l1;
    assign unused_l1 = ^{desc[19], desc[9], vaddr[VA_W-1:24]};

    always_comb begin
        res       = res_zero();
        is_table  = 1'b0;
        l2_base   = desc[DESC_W-1:L2_BASE_LSB];
        l1_domain = desc[8:5];
        unique case (desc[1:0])
            2'b00: begin
                res.fault  = 1'b1;
                res.flevel = 1'b0;
            end
            2'b01: begin
                is_table = 1'b1;
            end
            default: begin
                res.b   = desc[2];
                res.c   = desc[3];
                res.xn  = desc[4];
                res.ap  = {desc[15], desc[11:10]};
                res.tex = desc[14:12];
                res.s   = desc[16];
                res.ng  = desc[17];
                if (desc[SUPER_BIT]) begin
                    res.size   = PG_SUPER;
                    res.paddr  = {desc[31:24], vaddr[23:0]};
                    res.domain = '0;
                end else begin
                    res.size   = PG_SECTION;
                    res.paddr  = {desc[31:20], vaddr[19:0]};
                    res.domain = desc[8:5];
                end
            end
        endcase
    end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [DOM_W-1:0]  domain,
    output walk_res_t         res
);
    logic unused_l2;
    assign unused_l2 = ^{vaddr[VA_W-1:16]};

    always_comb begin
        res = res_zero();
        unique case (desc[1:0])
            2'b00: begin
                res.fault  = 1'b1;
                res.flevel = 1'b1;
            end
            2'b01: begin
                res.size   = PG_LARGE;
                res.paddr  = {desc[31:16], vaddr[15:0]};
                res.b      = desc[2];
                res.c      = desc[3];
                res.ap     = {desc[9], desc[5:4]};
                res.s      = desc[10];
                res.ng     = desc[11];
                res.tex    = desc[14:12];
                res.xn     = desc[15];
                res.domain = domain;
            end
            default: begin
                res.size   = PG_SMALL;
                res.paddr  = {desc[31:12], vaddr[11:0]};
                res.xn     = desc[0];
                res.b      = desc[2];
                res.c      = desc[3];
                res.ap     = {desc[9], desc[5:4]};
                res.tex    = desc[8:6];
                res.s      = desc[10];
                res.ng     = desc[11];
                res.domain = domain;
            end
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [PA_W-1:0]   req_base,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [DESC_W-1:0] mem_resp_data,
    output logic              done,
    output logic [PA_W-1:0]   res_paddr,
    output logic [1:0]        res_size,
    output logic [2:0]        res_tex,
    output logic              res_c,
    output logic              res_b,
    output logic              res_s,
    output logic [2:0]        res_ap,
    output logic              res_xn,
    output logic              res_ng,
    output logic [DOM_W-1:0]  res_domain,
    output logic              res_fault,
    output logic              res_fault_level
);
    typedef struct packed {
        walk_state_e      st;
        logic [VA_W-1:0]  va;
        logic [PA_W-1:0]  addr;
        logic [DOM_W-1:0] dom;
        walk_res_t        res;
        logic             done;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic                 l1_is_table;
    logic [L2_BASE_W-1:0] l1_l2_base;
    logic [DOM_W-1:0]     l1_dom;
    walk_res_t            l1_res;
    walk_res_t            l2_res;

    logic unused_base;
    assign unused_base = ^{req_base[L1_BASE_LSB-1:0]};

    ptw_l1_decode u_l1 (
        .desc      (mem_resp_data),
        .vaddr     (r_q.va),
        .is_table  (l1_is_table),
        .l2_base   (l1_l2_base),
        .l1_domain (l1_dom),
        .res       (l1_res)
    );

    ptw_l2_decode u_l2 (
        .desc   (mem_resp_data),
        .vaddr  (r_q.va),
        .domain (r_q.dom),
        .res    (l2_res)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            WS_IDLE: begin
                if (req_valid) begin
                    r_d.st   = WS_RD1;
                    r_d.va   = req_vaddr;
                    r_d.addr = {req_base[PA_W-1:L1_BASE_LSB],
                                req_vaddr[VA_W-1:L1_IDX_LSB], 2'b00};
                end
            end
            WS_RD1: begin
                if (mem_resp_valid) begin
                    if (l1_is_table) begin
                        r_d.st   = WS_RD2;
                        r_d.addr = {l1_l2_base,
                                    r_q.va[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};
                        r_d.dom  = l1_dom;
                    end else begin
                        r_d.st   = WS_IDLE;
                        r_d.res  = l1_res;
                        r_d.done = 1'b1;
                    end
                end
            end
            WS_RD2: begin
                if (mem_resp_valid) begin
                    r_d.st   = WS_IDLE;
                    r_d.res  = l2_res;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: WS_IDLE, va: '0, addr: '0, dom: '0,
                     res: res_zero(), done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy            = (r_q.st != WS_IDLE);
    assign mem_req_valid   = (r_q.st == WS_RD1) || (r_q.st == WS_RD2);
    assign mem_req_addr    = r_q.addr;
    assign done            = r_q.done;
    assign res_paddr       = r_q.res.paddr;
    assign res_size        = r_q.res.size;
    assign res_tex         = r_q.res.tex;
    assign res_c           = r_q.res.c;
    assign res_b           = r_q.res.b;
    assign res_s           = r_q.res.s;
    assign res_ap          = r_q.res.ap;
    assign res_xn          = r_q.res.xn;
    assign res_ng          = r_q.res.ng;
    assign res_domain      = r_q.res.domain;
    assign res_fault       = r_q.res.fault;
    assign res_fault_level = r_q.res.flevel;

    // R1: the captured address cannot move while a walk runs
    p_busy_ignores_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q.va));

    // R2: every read is word aligned
    p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    // R3: a faulting walk reports no address, attributes or domain
    p_fault_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault) |-> (res_paddr == '0 && res_domain == '0 && res_ap == '0));

    // R5: a supersection carries domain zero
    p_super_domain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !res_fault && res_size == PG_SUPER) |-> (res_domain == '0));

    // R10: an unanswered request holds its address
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_resp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R11: done lasts one cycle and coincides with idle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11: results only change when a walk completes
    p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !r_d.done |=> $stable(r_q.res));
endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_base = '0;
    logic        busy;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;
    logic        done;
    logic [31:0] res_paddr;
    logic [1:0]  res_size;
    logic [2:0]  res_tex;
    logic        res_c, res_b, res_s;
    logic [2:0]  res_ap;
    logic        res_xn, res_ng;
    logic [3:0]  res_domain;
    logic        res_fault, res_fault_level;

    always #2.5 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_base(req_base), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
        .mem_resp_data(mem_resp_data), .done(done), .res_paddr(res_paddr),
        .res_size(res_size), .res_tex(res_tex), .res_c(res_c), .res_b(res_b),
        .res_s(res_s), .res_ap(res_ap), .res_xn(res_xn), .res_ng(res_ng),
        .res_domain(res_domain), .res_fault(res_fault),
        .res_fault_level(res_fault_level)
    );

    int n_checks = 0;
    int n_fails  = 0;

    // memory model state, written by the main sequence before each walk
    logic [31:0] m_l1addr, m_l2addr, m_d1, m_d2;
    int          reads = 0;
    int          delay = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // memory responder with random latency
    always @(negedge clk) begin
        if (mem_resp_valid) begin
            mem_resp_valid <= 1'b0;
        end else if (!mem_req_valid) begin
            reads = 0;
        end else if (delay > 0) begin
            delay = delay - 1;
        end else begin
            if (reads == 0) begin
                check("R2 first read address", mem_req_addr, m_l1addr);
                mem_resp_data <= m_d1;
            end else begin
                check("R6 second read address", mem_req_addr, m_l2addr);
                mem_resp_data <= m_d2;
            end
            mem_resp_valid <= 1'b1;
            reads = reads + 1;
            delay = $urandom % 3;
        end
    end

    // expected result of one walk
    logic [31:0] e_pa;
    logic [1:0]  e_size;
    logic [14:0] e_attr;
    logic        e_fault, e_lvl;
    int          e_reads;

    task automatic model(input logic [31:0] base, input logic [31:0] va,
                         input logic [31:0] d1, input logic [31:0] d2);
        m_l1addr = {base[31:14], va[31:20], 2'b00};
        m_l2addr = {d1[31:10], va[19:12], 2'b00};
        m_d1 = d1;
        m_d2 = d2;
        e_pa = '0; e_size = '0; e_attr = '0; e_fault = 1'b0; e_lvl = 1'b0; e_reads = 1;
        if (d1[1:0] == 2'b00) begin
            e_fault = 1'b1;
        end else if (d1[1]) begin
            // attr order: tex, c, b, s, ap, xn, ng, domain
            e_attr = {d1[14:12], d1[3], d1[2], d1[16], d1[15], d1[11:10], d1[4], d1[17],
                      (d1[18] ? 4'd0 : d1[8:5])};
            e_size = d1[18] ? 2'd3 : 2'd2;
            e_pa   = d1[18] ? {d1[31:24], va[23:0]} : {d1[31:20], va[19:0]};
        end else begin
            e_reads = 2;
            if (d2[1:0] == 2'b00) begin
                e_fault = 1'b1;
                e_lvl   = 1'b1;
            end else if (d2[1:0] == 2'b01) begin
                e_size = 2'd1;
                e_pa   = {d2[31:16], va[15:0]};
                e_attr = {d2[14:12], d2[3], d2[2], d2[10], d2[9], d2[5:4], d2[15], d2[11], d1[8:5]};
            end else begin
                e_size = 2'd0;
                e_pa   = {d2[31:12], va[11:0]};
                e_attr = {d2[8:6], d2[3], d2[2], d2[10], d2[9], d2[5:4], d2[0], d2[11], d1[8:5]};
            end
        end
    endtask

    function automatic string kind_tag(input logic [31:0] d1, input logic [31:0] d2);
        if (d1[1:0] == 2'b00) return "R3 first-level fault";
        if (d1[1]) return d1[18] ? "R5 supersection" : "R4 section";
        if (d2[1:0] == 2'b00) return "R7 second-level fault";
        if (d2[1:0] == 2'b01) return "R8 large page";
        return "R9 small page";
    endfunction

    task automatic walk(input logic [31:0] base, input logic [31:0] va,
                        input logic [31:0] d1, input logic [31:0] d2, input bit stray);
        string tag;
        bit    got;
        logic [31:0] pa_seen;
        tag = kind_tag(d1, d2);
        model(base, va, d1, d2);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_base = base;
        @(negedge clk);
        req_valid = stray; req_vaddr = ~va; req_base = ~base;
        check("R1 busy after accept", {31'd0, busy}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        got = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (done) begin got = 1'b1; break; end
            @(negedge clk);
        end
        check({tag, " done seen"}, {31'd0, got}, 32'd1);
        check({tag, " paddr"}, res_paddr, e_pa);
        check({tag, " size"}, {30'd0, res_size}, {30'd0, e_size});
        check({tag, " attributes"},
              {17'd0, res_tex, res_c, res_b, res_s, res_ap, res_xn, res_ng, res_domain},
              {17'd0, e_attr});
        check({tag, " fault/level"}, {30'd0, res_fault, res_fault_level},
              {30'd0, e_fault, e_lvl});
        check("R10 read count", reads, e_reads);
        check("R11 busy low with done", {31'd0, busy}, 32'd0);
        pa_seen = res_paddr;
        @(negedge clk);
        check("R11 done is one cycle", {31'd0, done}, 32'd0);
        check("R11 result holds", res_paddr, pa_seen);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset busy", {31'd0, busy}, 32'd0);
        check("R11 reset done", {31'd0, done}, 32'd0);
        check("R11 reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);

        // directed: table at 0x000F_0000, slot 1 maps a section
        walk(32'h000F_0000, 32'h0010_0000, 32'h0020_0C02, 32'h0, 1'b0);
        walk(32'h000F_0000, 32'h0012_3456, 32'h0020_0C02, 32'h0, 1'b1);
        // directed: small page, base low bits set must be ignored
        walk(32'h000F_3FFF, 32'h4000_0123, 32'h0030_0001, 32'h0010_0002, 1'b1);
        walk(32'h000F_0000, 32'h4000_1ABC, 32'h0030_0001, 32'h0020_0032, 1'b0);
        // directed: supersection, large page, both faults
        walk(32'h8000_4000, 32'hABCD_EF01, 32'h5A04_0002, 32'h0, 1'b0);
        walk(32'h8000_4000, 32'h1234_5678, 32'h0044_41E1, 32'hFEDC_B271, 1'b1);
        walk(32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 32'h0, 1'b1);
        walk(32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFC, 1'b0);

        for (int n = 0; n < 400; n++) begin
            logic [31:0] b, v, d1, d2;
            int t;
            b  = $urandom; v = $urandom; d1 = $urandom; d2 = $urandom;
            t  = $urandom % 6;
            case (t)
                0: d1 = d1 & ~32'h3;
                1: d1 = (d1 & ~32'h0004_0000) | 32'h2;
                2: d1 = d1 | 32'h0004_0002;
                3: begin d1 = (d1 & ~32'h3) | 32'h1; d2 = d2 & ~32'h3; end
                4: begin d1 = (d1 & ~32'h3) | 32'h1; d2 = (d2 & ~32'h3) | 32'h1; end
                default: begin d1 = (d1 & ~32'h3) | 32'h1; d2 = d2 | 32'h2; end
            endcase
            walk(b, v, d1, d2, bit'($urandom % 2));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule